// File: doc/BRIEF.md
# Programmable Clock Output Stage

This block is the digital back end of a programmable clock generator. It takes two source strobes, one from the PLL and one from the crystal oscillator, and picks one of them. It divides the chosen source by a power of two from 1 to 128 and drives the result as the clock output. One active-low control pin governs that output. The whole block runs on one fast sampling clock. Each source is presented as a one-cycle tick strobe, so the divided clock is a registered level in that clock domain.

Configuration inputs set the divider ratio, the source, the pin's effect and the pin's timing. The pin can either tri-state the pad or power down the part. The timing is either immediate or aligned to the divided clock. In power-down the output is held low and a shutdown request goes out to the analog parts. After power-down ends, the output waits for a lock indication before it runs again. A new ratio or source is taken only while the output is off or powered down. This keeps the running clock free of odd-length periods.

Top module: `clkout_stage`

## Requirements
- R1: While running, `clk_out` holds each level for exactly 2^`div_sel` selected source ticks, so its period is 2^(`div_sel`+1) ticks, for every `div_sel` value 0 to 7.
- R2: `src_sel`=0 counts `pll_ce` strobes and `src_sel`=1 counts `xtal_ce` strobes. The strobe of the unselected source has no effect on `clk_out`.
- R3: With `pm_pd`=0 (output-enable mode), a low `ctl_n` drives `out_en` to 0. The divider keeps running, and `clk_out` goes on toggling behind the disabled pad.
- R4: With `pm_pd`=1 (power-down mode), a low `ctl_n` sets `pd_req` to 1 and forces `clk_out` to 0, while `out_en` stays 1.
- R5: With `sync_tm`=0, the pin acts at the first clock edge after it is sampled, at any phase of `clk_out`. With `sync_tm`=1, it first passes through a two-flop synchronizer, so at least two more edges go by before the output reacts.
- R6: With `sync_tm`=1, a disable or a power-down takes effect only at an edge where the divided clock was low, so `clk_out` is never cut short while high.
- R7: With `sync_tm`=1 in output-enable mode, re-enabling takes effect only while the divided clock is low, and the first high pulse after re-enabling has full width.
- R8: After power-down ends, `pd_req` drops and `clk_out` stays 0 until `lock_in` is 1. The divider then restarts from reset, and the first rising edge comes 2^`div_sel` ticks after the lock edge.
- R9: Changes on `div_sel` and `src_sel` are ignored while the output is running. They are taken while the output is disabled or powered down.
- R10: During reset, `out_en`=1, `pd_req`=0 and `clk_out`=0. The configuration present during reset is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of the whole stage |
| rst | input | 1 | Synchronous active-high reset |
| pll_ce | input | 1 | One-cycle tick per PLL source edge |
| xtal_ce | input | 1 | One-cycle tick per crystal source edge |
| div_sel | input | 3 | Divider exponent, ratio 2^div_sel |
| src_sel | input | 1 | 0 selects PLL ticks, 1 selects crystal ticks |
| pm_pd | input | 1 | 0 selects output-enable mode, 1 selects power-down mode |
| sync_tm | input | 1 | 0 selects immediate timing, 1 selects output-aligned timing |
| ctl_n | input | 1 | Active-low control pin |
| lock_in | input | 1 | Oscillator and PLL lock indication |
| clk_out | output | 1 | Divided clock level |
| out_en | output | 1 | Pad driver enable, 0 means high impedance |
| pd_req | output | 1 | Request to shut down active circuitry |

## Verification
The case that matters is a disable or re-enable request that reaches the gate in the same cycle as a divider toggle. The bench sweeps the pin's falling moment over all eight phases of a divide-by-4 clock in aligned timing. At the edge where `out_en` changes, it checks that `clk_out` was low one sample earlier. It also checks that the first pulse after re-enabling lasts the full four cycles. Immediate timing is exercised against a high output, where cutting the pulse short is the expected result.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_OFF  = 2'd1,
    ST_PDN  = 2'd2,
    ST_LOCK = 2'd3
  } gate_st_t;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/ckdiv_core.sv
module ckdiv_core #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             div_q
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lim;

  assign span = (CNT_W+1)'(1) << sel;
  assign lim  = CNT_W'(span - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (tick) begin
      if (cnt >= lim) begin
        cnt   <= '0;
        div_q <= ~div_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(div_q));

  // R8
  clr_low_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !div_q);
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
  import clkout_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ctl_raw_n,
  input  logic     ctl_sync_n,
  input  logic     mode_pd,
  input  logic     timing_sync,
  input  logic     lock_in,
  input  logic     div_q,
  output gate_st_t state
);
  gate_st_t state_n;
  logic     off_req;
  logic     phase_ok;
  logic     past_ok;

  assign off_req  = timing_sync ? !ctl_sync_n : !ctl_raw_n;
  assign phase_ok = !timing_sync || !div_q;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_RUN:  if (off_req && phase_ok) state_n = mode_pd ? ST_PDN : ST_OFF;
      ST_OFF: begin
        if (off_req && mode_pd)          state_n = ST_PDN;
        else if (!off_req && phase_ok)   state_n = ST_RUN;
      end
      ST_PDN:  if (!off_req) state_n = ST_LOCK;
      ST_LOCK: begin
        if (off_req)      state_n = mode_pd ? ST_PDN : ST_OFF;
        else if (lock_in) state_n = ST_RUN;
      end
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      past_ok <= 1'b0;
    end else begin
      state   <= state_n;
      past_ok <= 1'b1;
    end
  end

  // R6
  sync_leave_low_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && timing_sync && $past(timing_sync) && $past(state) == ST_RUN
     && state != ST_RUN) |-> !$past(div_q));

  // R7
  sync_enter_low_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && timing_sync && $past(timing_sync) && $past(state) == ST_OFF
     && state == ST_RUN) |-> !$past(div_q));

  // R8
  lock_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && !lock_in) |=> state != ST_RUN);
endmodule

// File: rtl/clkout_stage.sv
module clkout_stage
  import clkout_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pll_ce,
  input  logic             xtal_ce,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             src_sel,
  input  logic             pm_pd,
  input  logic             sync_tm,
  input  logic             ctl_n,
  input  logic             lock_in,
  output logic             clk_out,
  output logic             out_en,
  output logic             pd_req
);
  gate_st_t         state;
  logic [SEL_W-1:0] sel_q;
  logic             src_q;
  logic             ctl_s_n;
  logic             tick;
  logic             div_q;
  logic             clr;
  logic             cfg_open;
  logic             past_ok;

  ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (ctl_n),
    .dout (ctl_s_n)
  );

  assign cfg_open = (state == ST_OFF) || (state == ST_PDN);

  always_ff @(posedge clk) begin
    if (rst || cfg_open) begin
      sel_q <= div_sel;
      src_q <= src_sel;
    end
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign tick = src_q ? xtal_ce : pll_ce;
  assign clr  = (state == ST_PDN) || (state == ST_LOCK);

  ckdiv_core #(.SEL_W(SEL_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .tick  (tick),
    .sel   (sel_q),
    .div_q (div_q)
  );

  gate_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .ctl_raw_n   (ctl_n),
    .ctl_sync_n  (ctl_s_n),
    .mode_pd     (pm_pd),
    .timing_sync (sync_tm),
    .lock_in     (lock_in),
    .div_q       (div_q),
    .state       (state)
  );

  assign clk_out = div_q && ((state == ST_RUN) || (state == ST_OFF));
  assign out_en  = (state != ST_OFF);
  assign pd_req  = (state == ST_PDN);

  // R4
  pd_low_chk: assert property (@(posedge clk) disable iff (rst)
    pd_req |-> (!clk_out && out_en));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && state == ST_RUN && $past(state) == ST_RUN)
      |-> ($stable(sel_q) && $stable(src_q)));
endmodule

// File: tb/clkout_stage_test.sv
module clkout_stage_test;
  logic       clk = 1'b0;
  logic       rst, pll_ce, xtal_ce, src_sel, pm_pd, sync_tm, ctl_n, lock_in;
  logic [2:0] div_sel;
  logic       clk_out, out_en, pd_req;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  clkout_stage uut (
    .clk(clk), .rst(rst), .pll_ce(pll_ce), .xtal_ce(xtal_ce),
    .div_sel(div_sel), .src_sel(src_sel), .pm_pd(pm_pd), .sync_tm(sync_tm),
    .ctl_n(ctl_n), .lock_in(lock_in),
    .clk_out(clk_out), .out_en(out_en), .pd_req(pd_req)
  );

  initial begin
    int ph = 0;
    xtal_ce = 1'b0;
    forever begin
      @(negedge clk);
      xtal_ce = (ph == 2);
      ph = (ph + 1) % 3;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_rise();
    logic prev = clk_out;
    for (int i = 0; i < 3000; i++) begin
      step();
      if (clk_out && !prev) return;
      prev = clk_out;
    end
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (clk_out == lvl && n < 3000) begin
      n++;
      step();
    end
  endtask

  initial begin
    int hi, lo, n, tp, tog;
    logic prev;
    rst = 1'b1; pll_ce = 1'b1; div_sel = 3'd1; src_sel = 1'b0;
    pm_pd = 1'b0; sync_tm = 1'b0; ctl_n = 1'b1; lock_in = 1'b1;
    step(); step(); step();
    // R10 reset state
    chk(out_en == 1'b1 && pd_req == 1'b0 && clk_out == 1'b0, "R10 reset outputs",
        {out_en, pd_req, clk_out}, 3'b100);
    rst = 1'b0;
    wait_rise(); run_len(1'b1, hi);
    chk(hi == 2, "R10 reset config loaded", hi, 2);

    // R1 R2 sweep over every source and ratio
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 8; d++) begin
        ctl_n = 1'b0; step();
        src_sel = s[0]; div_sel = d[2:0]; step(); step();
        ctl_n = 1'b1;
        tp = (s == 1) ? 3 : 1;
        wait_rise(); run_len(1'b1, hi); run_len(1'b0, lo);
        chk(hi == tp * (1 << d), s ? "R2 xtal high width" : "R1 pll high width", hi, tp * (1 << d));
        chk(lo == tp * (1 << d), s ? "R2 xtal low width" : "R1 pll low width", lo, tp * (1 << d));
      end
    end

    // R9 config ignored while running, taken after a disable
    src_sel = 1'b0; ctl_n = 1'b0; step(); div_sel = 3'd1; step(); ctl_n = 1'b1;
    wait_rise(); div_sel = 3'd3;
    run_len(1'b1, hi); wait_rise(); run_len(1'b1, hi);
    chk(hi == 2, "R9 change ignored while running", hi, 2);
    ctl_n = 1'b0; step(); step(); ctl_n = 1'b1;
    wait_rise(); run_len(1'b1, hi);
    chk(hi == 8, "R9 change taken after disable", hi, 8);

    // R5 R3 immediate disable while high, divider keeps running
    ctl_n = 1'b0; step(); div_sel = 3'd2; step(); ctl_n = 1'b1;
    wait_rise(); step();
    ctl_n = 1'b0; step();
    chk(out_en == 1'b0, "R5 async disable next edge", out_en, 0);
    tog = 0; prev = clk_out;
    for (int i = 0; i < 16; i++) begin
      step(); if (clk_out != prev) tog++; prev = clk_out;
    end
    chk(tog == 4, "R3 divider runs while disabled", tog, 4);
    ctl_n = 1'b1; step();
    chk(out_en == 1'b1, "R3 quick return", out_en, 1);

    // R5 R6 R7 aligned timing over all phases of a divide-by-4 clock
    sync_tm = 1'b1; step(); step();
    for (int p = 0; p < 8; p++) begin
      wait_rise();
      for (int k = 0; k < p; k++) step();
      ctl_n = 1'b0; n = 0; prev = clk_out;
      step();
      while (out_en && n < 40) begin n++; prev = clk_out; step(); end
      chk(n >= 2, "R5 sync latency", n, 2);
      chk(prev == 1'b0, "R6 disable while low", prev, 0);
      step(); step();
      ctl_n = 1'b1; n = 0; prev = clk_out;
      step();
      while (!out_en && n < 40) begin n++; prev = clk_out; step(); end
      chk(prev == 1'b0, "R7 enable while low", prev, 0);
      n = 0;
      while (!clk_out && n < 40) begin n++; step(); end
      run_len(1'b1, hi);
      chk(hi == 4, "R7 first pulse full width", hi, 4);
    end

    // R6 aligned power-down entry
    pm_pd = 1'b1; wait_rise(); step();
    ctl_n = 1'b0; n = 0; prev = clk_out; step();
    while (!pd_req && n < 40) begin n++; prev = clk_out; step(); end
    chk(prev == 1'b0, "R6 sync power-down while low", prev, 0);
    ctl_n = 1'b1;
    for (int i = 0; i < 5; i++) step();
    sync_tm = 1'b0; step();

    // R4 R8 power-down and relock
    ctl_n = 1'b0; step(); div_sel = 3'd1; lock_in = 1'b0; step();
    chk(pd_req == 1'b1 && clk_out == 1'b0 && out_en == 1'b1, "R4 power-down outputs",
        {pd_req, clk_out, out_en}, 3'b101);
    ctl_n = 1'b1; step();
    chk(pd_req == 1'b0, "R8 request drops", pd_req, 0);
    n = 0;
    for (int i = 0; i < 10; i++) begin step(); if (clk_out) n++; end
    chk(n == 0, "R8 low until lock", n, 0);
    lock_in = 1'b1; n = 0;
    step();
    while (!clk_out && n < 40) begin n++; step(); end
    chk(n == 2, "R8 restart from reset", n, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule